// File: doc/BRIEF.md
# Fully Associative Address Translation Buffer with Page Protection

This block turns virtual addresses into physical addresses for a processor whose cache is physically addressed. A lookup carries a virtual address and an access kind: read, write or instruction fetch. The virtual page number is compared against every stored translation at once. The result appears one cycle later as one of three outcomes. The first is a granted translation with its physical address. The second is a miss exception, raised when no valid entry holds the page. The third is a protection exception, raised when the page forbids the access.

There is no hardware page-table walker. Every miss traps to software, which reads the process page table and writes the translation through a separate refill port. Software then replays the access. Each entry stores a physical page number, a write-permit bit and a no-execute bit. A flush input drops every translation in one cycle when the running process changes.

Top module: `tlb_xlate`

## Requirements
- R1: While reset is held and in the first cycle after it, `rsp_hit`, `rsp_miss`, `rsp_prot` and `rsp_paddr` are 0. Every entry is invalid after reset, so the first lookup reports a miss.
- R2: A lookup whose virtual page number (`req_vaddr[VADDR_W-1:OFF_W]`) matches no valid entry sets `rsp_miss` to 1 in the next cycle. In that cycle `rsp_hit`, `rsp_prot` and `rsp_paddr` are 0.
- R3: A permitted lookup that matches an entry sets `rsp_hit` to 1 in the next cycle. `rsp_paddr` then equals the stored physical page number in the upper bits, joined with `req_vaddr[OFF_W-1:0]` unchanged in the low `OFF_W` bits. `OFF_W` is log2 of `PAGE_BYTES` (12 by default).
- R4: A translation written to any of the `ENTRIES` slots is found by lookup, so the buffer is fully associative.
- R5: A write (`req_acc` = 2'd1) that matches an entry whose write-permit bit is 0 sets `rsp_prot` to 1, with `rsp_hit` = 0 and `rsp_paddr` = 0. A write to a page with write-permit 1 is granted.
- R6: A fetch (`req_acc` = 2'd2) that matches an entry whose no-execute bit is 1 sets `rsp_prot` to 1. A read (`req_acc` = 2'd0, and also code 2'd3) ignores both permission bits.
- R7: A refill whose virtual page number equals that of a valid entry overwrites that entry and ignores `fill_idx`. The slot named by `fill_idx` is left unchanged, and no two valid entries ever match one page.
- R8: `flush` invalidates every entry in one cycle. A refill presented in the same cycle is discarded.
- R9: At most one of `rsp_hit`, `rsp_miss` and `rsp_prot` is 1 in any cycle. All three are 0 in the cycle after a cycle with `req_valid` low.
- R10: A refill takes effect for lookups presented from the next cycle onward. An access that missed, once its entry is refilled, hits when it is retried.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Lookup request present |
| req_vaddr | input | VADDR_W | Virtual address to translate |
| req_acc | input | 2 | Access kind: 0 read, 1 write, 2 fetch |
| fill_en | input | 1 | Write one translation this cycle |
| fill_idx | input | IDX_W | Slot to write when the page is not already present |
| fill_vpn | input | VPN_W | Virtual page number of the new translation |
| fill_ppn | input | PPN_W | Physical page number of the new translation |
| fill_wr_ok | input | 1 | Write-permit bit of the new translation |
| fill_no_exec | input | 1 | No-execute bit of the new translation |
| flush | input | 1 | Invalidate every entry |
| rsp_hit | output | 1 | Translation granted (registered) |
| rsp_paddr | output | PADDR_W | Physical address, valid with rsp_hit |
| rsp_miss | output | 1 | Miss exception (registered) |
| rsp_prot | output | 1 | Protection exception (registered) |

## Verification
The hardest state to reach is a refill whose page already lives in a slot other than the one `fill_idx` names. Only that case exposes a missing duplicate check, and the fault shows up only on a later lookup. The bench first fills all slots with distinct pages and permission patterns. It then refills slot 0 with the page held in slot 5, using a new physical page. It reads both pages back to confirm that slot 5 took the new mapping and that slot 0 kept its old one. A flush presented together with a refill is also driven, followed by lookups of both the flushed pages and the refilled page.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  typedef enum logic [1:0] {
    ACC_READ  = 2'd0,
    ACC_WRITE = 2'd1,
    ACC_FETCH = 2'd2,
    ACC_RSVD  = 2'd3
  } acc_e;
endpackage

// File: rtl/tlb_entry.sv
module tlb_entry #(
  parameter int VPN_W = 20,
  parameter int PPN_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             wr_en,
  input  logic [VPN_W-1:0] wr_vpn,
  input  logic [PPN_W-1:0] wr_ppn,
  input  logic             wr_ok,
  input  logic             wr_nx,
  input  logic [VPN_W-1:0] look_vpn,
  output logic             look_match,
  output logic             fill_match,
  output logic [PPN_W-1:0] ppn,
  output logic             wr_permit,
  output logic             no_exec
);
  logic             valid_q, valid_nxt;
  logic [VPN_W-1:0] vpn_q, vpn_nxt;
  logic [PPN_W-1:0] ppn_q, ppn_nxt;
  logic             ok_q, ok_nxt;
  logic             nx_q, nx_nxt;

  always_comb begin
    valid_nxt = valid_q;
    vpn_nxt   = vpn_q;
    ppn_nxt   = ppn_q;
    ok_nxt    = ok_q;
    nx_nxt    = nx_q;
    if (clr) begin
      valid_nxt = 1'b0;
    end else if (wr_en) begin
      valid_nxt = 1'b1;
      vpn_nxt   = wr_vpn;
      ppn_nxt   = wr_ppn;
      ok_nxt    = wr_ok;
      nx_nxt    = wr_nx;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      vpn_q   <= '0;
      ppn_q   <= '0;
      ok_q    <= 1'b0;
      nx_q    <= 1'b0;
    end else begin
      valid_q <= valid_nxt;
      vpn_q   <= vpn_nxt;
      ppn_q   <= ppn_nxt;
      ok_q    <= ok_nxt;
      nx_q    <= nx_nxt;
    end
  end

  assign look_match = valid_q && (vpn_q == look_vpn);
  assign fill_match = valid_q && (vpn_q == wr_vpn);
  assign ppn        = ppn_q;
  assign wr_permit  = ok_q;
  assign no_exec    = nx_q;

  assert_flush_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> !look_match && !fill_match);

  assert_write_lands_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !clr) |=> (ppn == $past(wr_ppn)) && (look_vpn != $past(wr_vpn) || look_match));
endmodule

// File: rtl/tlb_select.sv
module tlb_select #(
  parameter int N     = 32,
  parameter int PPN_W = 12
) (
  input  logic [N-1:0]            sel,
  input  logic [N-1:0][PPN_W-1:0] ppn_in,
  input  logic [N-1:0]            ok_in,
  input  logic [N-1:0]            nx_in,
  output logic                    any,
  output logic [PPN_W-1:0]        ppn,
  output logic                    wr_permit,
  output logic                    no_exec
);
  always_comb begin
    ppn       = '0;
    wr_permit = 1'b0;
    no_exec   = 1'b0;
    for (int i = 0; i < N; i++) begin
      if (sel[i]) begin
        ppn       = ppn | ppn_in[i];
        wr_permit = wr_permit | ok_in[i];
        no_exec   = no_exec | nx_in[i];
      end
    end
  end
  assign any = |sel;
endmodule

// File: rtl/tlb_resp.sv
module tlb_resp
  import tlb_pkg::*;
#(
  parameter int PPN_W = 12,
  parameter int OFF_W = 12
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   req_valid,
  input  logic [1:0]             req_acc,
  input  logic [OFF_W-1:0]       req_off,
  input  logic                   found,
  input  logic [PPN_W-1:0]       ppn,
  input  logic                   wr_permit,
  input  logic                   no_exec,
  output logic                   rsp_hit,
  output logic [PPN_W+OFF_W-1:0] rsp_paddr,
  output logic                   rsp_miss,
  output logic                   rsp_prot
);
  acc_e acc;
  logic deny;
  logic hit_nxt, miss_nxt, prot_nxt;
  logic [PPN_W+OFF_W-1:0] paddr_nxt;

  assign acc  = acc_e'(req_acc);
  assign deny = ((acc == ACC_WRITE) && !wr_permit) || ((acc == ACC_FETCH) && no_exec);

  always_comb begin
    hit_nxt   = 1'b0;
    miss_nxt  = 1'b0;
    prot_nxt  = 1'b0;
    paddr_nxt = '0;
    if (req_valid) begin
      if (!found) begin
        miss_nxt = 1'b1;
      end else if (deny) begin
        prot_nxt = 1'b1;
      end else begin
        hit_nxt   = 1'b1;
        paddr_nxt = {ppn, req_off};
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_hit   <= 1'b0;
      rsp_miss  <= 1'b0;
      rsp_prot  <= 1'b0;
      rsp_paddr <= '0;
    end else begin
      rsp_hit   <= hit_nxt;
      rsp_miss  <= miss_nxt;
      rsp_prot  <= prot_nxt;
      rsp_paddr <= paddr_nxt;
    end
  end

  assert_single_outcome_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({rsp_hit, rsp_miss, rsp_prot}) <= 1);

  assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_hit && !rsp_miss && !rsp_prot);

  assert_read_never_denied_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && (req_acc == 2'd0)) |=> !rsp_prot);

  assert_offset_passes_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && found && !deny) |=> rsp_hit && (rsp_paddr[OFF_W-1:0] == $past(req_off)));
endmodule

// File: rtl/tlb_xlate.sv
module tlb_xlate #(
  parameter int ENTRIES    = 32,
  parameter int VADDR_W    = 32,
  parameter int PADDR_W    = 24,
  parameter int PAGE_BYTES = 4096,
  localparam int OFF_W     = $clog2(PAGE_BYTES),
  localparam int VPN_W     = VADDR_W - OFF_W,
  localparam int PPN_W     = PADDR_W - OFF_W,
  localparam int IDX_W     = $clog2(ENTRIES)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  input  logic [VADDR_W-1:0] req_vaddr,
  input  logic [1:0]         req_acc,
  input  logic               fill_en,
  input  logic [IDX_W-1:0]   fill_idx,
  input  logic [VPN_W-1:0]   fill_vpn,
  input  logic [PPN_W-1:0]   fill_ppn,
  input  logic               fill_wr_ok,
  input  logic               fill_no_exec,
  input  logic               flush,
  output logic               rsp_hit,
  output logic [PADDR_W-1:0] rsp_paddr,
  output logic               rsp_miss,
  output logic               rsp_prot
);
  logic [VPN_W-1:0]              look_vpn;
  logic [ENTRIES-1:0]            look_vec;
  logic [ENTRIES-1:0]            fill_vec;
  logic [ENTRIES-1:0]            wr_vec;
  logic [ENTRIES-1:0][PPN_W-1:0] ent_ppn;
  logic [ENTRIES-1:0]            ent_ok;
  logic [ENTRIES-1:0]            ent_nx;
  logic                          fill_dup;
  logic                          found;
  logic [PPN_W-1:0]              sel_ppn;
  logic                          sel_ok;
  logic                          sel_nx;

  assign look_vpn = req_vaddr[VADDR_W-1:OFF_W];
  assign fill_dup = |fill_vec;

  always_comb begin
    wr_vec = '0;
    if (fill_en && !flush) begin
      for (int i = 0; i < ENTRIES; i++) begin
        wr_vec[i] = fill_dup ? fill_vec[i] : (fill_idx == IDX_W'(i));
      end
    end
  end

  for (genvar g = 0; g < ENTRIES; g++) begin : g_slot
    tlb_entry #(.VPN_W(VPN_W), .PPN_W(PPN_W)) u_entry (
      .clk        (clk),
      .rst_n      (rst_n),
      .clr        (flush),
      .wr_en      (wr_vec[g]),
      .wr_vpn     (fill_vpn),
      .wr_ppn     (fill_ppn),
      .wr_ok      (fill_wr_ok),
      .wr_nx      (fill_no_exec),
      .look_vpn   (look_vpn),
      .look_match (look_vec[g]),
      .fill_match (fill_vec[g]),
      .ppn        (ent_ppn[g]),
      .wr_permit  (ent_ok[g]),
      .no_exec    (ent_nx[g])
    );
  end

  tlb_select #(.N(ENTRIES), .PPN_W(PPN_W)) u_select (
    .sel       (look_vec),
    .ppn_in    (ent_ppn),
    .ok_in     (ent_ok),
    .nx_in     (ent_nx),
    .any       (found),
    .ppn       (sel_ppn),
    .wr_permit (sel_ok),
    .no_exec   (sel_nx)
  );

  tlb_resp #(.PPN_W(PPN_W), .OFF_W(OFF_W)) u_resp (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_acc   (req_acc),
    .req_off   (req_vaddr[OFF_W-1:0]),
    .found     (found),
    .ppn       (sel_ppn),
    .wr_permit (sel_ok),
    .no_exec   (sel_nx),
    .rsp_hit   (rsp_hit),
    .rsp_paddr (rsp_paddr),
    .rsp_miss  (rsp_miss),
    .rsp_prot  (rsp_prot)
  );

  assert_no_duplicate_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(look_vec) && $onehot0(fill_vec));

  assert_one_slot_written_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(wr_vec));

  assert_flush_drops_fill_R8: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (look_vec == '0));
endmodule

// File: tb/tlb_xlate_test.sv
module tlb_xlate_test;
  localparam int N = 32;
  localparam int VW = 32, PW = 24, OW = 12;
  localparam int VPW = VW - OW, PPW = PW - OW, IW = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic [VW-1:0] req_vaddr = '0;
  logic [1:0] req_acc = 2'd0;
  logic fill_en = 1'b0;
  logic [IW-1:0] fill_idx = '0;
  logic [VPW-1:0] fill_vpn = '0;
  logic [PPW-1:0] fill_ppn = '0;
  logic fill_wr_ok = 1'b0, fill_no_exec = 1'b0, flush = 1'b0;
  logic rsp_hit, rsp_miss, rsp_prot;
  logic [PW-1:0] rsp_paddr;

  int checks = 0, errors = 0;
  bit done = 1'b0;

  logic           mval [N];
  logic [VPW-1:0] mvpn [N];
  logic [PPW-1:0] mppn [N];
  logic           mok  [N];
  logic           mnx  [N];

  always #4 clk = ~clk;

  tlb_xlate uut (.*);

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic model_fill(input int idx, input logic [VPW-1:0] v, input logic [PPW-1:0] p,
                            input logic ok, input logic nx);
    int slot = idx;
    for (int i = 0; i < N; i++) if (mval[i] && mvpn[i] == v) slot = i;
    mval[slot] = 1'b1; mvpn[slot] = v; mppn[slot] = p; mok[slot] = ok; mnx[slot] = nx;
  endtask

  task automatic do_fill(input int idx, input logic [VPW-1:0] v, input logic [PPW-1:0] p,
                         input logic ok, input logic nx);
    fill_en = 1'b1; fill_idx = IW'(idx); fill_vpn = v; fill_ppn = p;
    fill_wr_ok = ok; fill_no_exec = nx;
    model_fill(idx, v, p, ok, nx);
    @(negedge clk);
    fill_en = 1'b0;
  endtask

  // exp computed from the model; sampled one negedge after the request edge
  task automatic lookup(input logic [VPW-1:0] v, input logic [OW-1:0] off, input logic [1:0] acc,
                        input string tag);
    logic eh, em, ep;
    logic [PW-1:0] ea;
    int m = -1;
    for (int i = 0; i < N; i++) if (mval[i] && mvpn[i] == v) m = i;
    eh = 0; em = 0; ep = 0; ea = '0;
    if (m < 0) em = 1;
    else if ((acc == 2'd1 && !mok[m]) || (acc == 2'd2 && mnx[m])) ep = 1;
    else begin eh = 1; ea = {mppn[m], off}; end
    req_valid = 1'b1; req_vaddr = {v, off}; req_acc = acc;
    @(negedge clk);
    req_valid = 1'b0;
    chk({rsp_hit, rsp_miss, rsp_prot} == {eh, em, ep}, tag,
        {29'd0, rsp_hit, rsp_miss, rsp_prot}, {29'd0, eh, em, ep});
    chk(rsp_paddr == ea, tag, {8'd0, rsp_paddr}, {8'd0, ea});
  endtask

  function automatic logic [VPW-1:0] pv(input int i);
    return VPW'(i * 37 + 5);
  endfunction
  function automatic logic [PPW-1:0] pp(input int i);
    return PPW'(i * 3 + 1) ^ 12'hA50;
  endfunction

  initial begin
    #(8 * 20000);
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < N; i++) begin
      mval[i] = 0; mvpn[i] = '0; mppn[i] = '0; mok[i] = 0; mnx[i] = 0;
    end
    repeat (3) @(negedge clk);
    chk({rsp_hit, rsp_miss, rsp_prot} == 3'b000 && rsp_paddr == '0, "R1 in reset",
        {rsp_hit, rsp_miss, rsp_prot, rsp_paddr[7:0]}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk({rsp_hit, rsp_miss, rsp_prot} == 3'b000, "R1 after release",
        {29'd0, rsp_hit, rsp_miss, rsp_prot}, 32'd0);
    lookup(20'h00123, 12'h456, 2'd0, "R1 empty misses");

    // miss, refill, retry
    lookup(20'hABCDE, 12'h321, 2'd1, "R2 miss before refill");
    do_fill(7, 20'hABCDE, 12'h5A5, 1'b1, 1'b0);
    lookup(20'hABCDE, 12'h321, 2'd1, "R10 retry hits");
    flush = 1'b1;
    for (int i = 0; i < N; i++) mval[i] = 0;
    @(negedge clk);
    flush = 1'b0;
    lookup(20'hABCDE, 12'h321, 2'd0, "R8 flushed entry misses");

    // fill every slot, sweep all access kinds
    for (int i = 0; i < N; i++) do_fill(i, pv(i), pp(i), i[0], i[1]);
    for (int i = 0; i < N; i++) begin
      for (int a = 0; a < 4; a++) begin
        lookup(pv(i), OW'(i * 97 + a * 13), 2'(a),
               a == 1 ? "R5 write permission" : (a == 2 ? "R6 fetch no-exec" : "R4 R3 read any slot"));
      end
    end
    for (int k = 0; k < 16; k++) lookup(20'hF0000 + VPW'(k), OW'(k * 255), 2'(k % 3), "R2 absent page");

    // idle cycle
    @(negedge clk);
    chk({rsp_hit, rsp_miss, rsp_prot} == 3'b000, "R9 idle quiet",
        {29'd0, rsp_hit, rsp_miss, rsp_prot}, 32'd0);

    // duplicate refill steered to existing slot
    do_fill(0, pv(5), 12'h777, 1'b1, 1'b0);
    lookup(pv(5), 12'hFFF, 2'd1, "R7 dup refill overwrote owner");
    lookup(pv(0), 12'h000, 2'd0, "R7 named slot untouched");
    lookup(pv(5), 12'h001, 2'd2, "R7 new bits apply");

    // flush with concurrent refill
    flush = 1'b1; fill_en = 1'b1; fill_idx = 5'd3; fill_vpn = 20'h55555; fill_ppn = 12'h123;
    fill_wr_ok = 1'b1; fill_no_exec = 1'b0;
    for (int i = 0; i < N; i++) mval[i] = 0;
    @(negedge clk);
    flush = 1'b0; fill_en = 1'b0;
    lookup(20'h55555, 12'h010, 2'd0, "R8 refill under flush dropped");
    for (int i = 0; i < N; i += 4) lookup(pv(i), 12'h0AB, 2'd0, "R8 all entries gone");

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule